// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block places a fixed list of internal digital peripheral signals onto a bank of sixteen general-purpose pins. The pins form two ports of eight. A seventeenth pin is also present. It always behaves as a plain GPIO and never carries a peripheral signal. Pins are not tied to peripherals at fixed positions. The enabled signals are laid out in a fixed priority order, and each one takes the lowest-numbered pin that is neither skipped nor already taken. Turning one peripheral on or off can therefore move every lower-priority signal to a different pin.

Any pin that carries no peripheral signal acts as GPIO and is driven from its port latch bit. Every pin drives in one of two modes, push-pull or open-drain, chosen by a mode bit for that pin. The value on every pin is always returned through a readback register, whatever the current assignment. If the free pins run out, the signals that do not fit stay unconnected and a status flag is raised.

The assignment logic is combinational. The pin drive outputs and the status flag are registered. A change in configuration therefore shows at the pins one clock edge later.

Top module: `pin_xbar`

## Requirements
- R1: While reset is active, and until the first load after it, pin_out, pin_oe, pin_periph, latch_rd and overflow are all 0.
- R2: The signal list has twelve entries in fixed priority order, with index 0 highest. Index 0 is serial tx and index 1 is serial rx (owner enable bit 0). Indexes 2 to 5 are the SPI sck, miso, mosi and select signals (bit 1). Indexes 6 and 7 are the two-wire data and clock signals (bit 2). Index 8 is the comparator output (bit 3). Index 9 is the clock output (bit 4). Indexes 10 and 11 are the two capture inputs (bit 5). Each signal whose owner is enabled takes the lowest-numbered free pin that no higher-priority signal has taken.
- R3: A pin whose pin_skip bit is 1 never carries a peripheral signal (its pin_periph bit is 0).
- R4: Every pin that carries no signal is GPIO and is driven from its port_latch bit. This includes pin 16, which is never a peripheral pin.
- R5: A pin that carries an output-type signal drives per_out at that signal's index. A pin that carries an input-type signal (indexes 1, 3, 10, 11) is not driven. per_in at a placed signal's index equals pin_in at its assigned pin.
- R6: When pin_pushpull is 1 for a pin, pin_out equals the drive value and pin_oe equals the drive request. When it is 0 (open-drain), pin_out is 0 and pin_oe is 1 only when the drive is requested and the value is 0.
- R7: Signals that find no free pin stay unconnected, and their per_in bit reads the idle level 1. overflow is 1 exactly when more signals are enabled than there are non-skipped pins.
- R8: latch_rd equals the value pin_in had at the previous clock edge, for every pin and whatever the assignment.
- R9: pin_out, pin_oe, pin_periph and overflow follow a change on any configuration or data input at the next clock edge. per_in follows pin_in and the configuration without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 6 | Enable bit for each peripheral |
| pin_skip | input | 16 | Skip bit for each crossbar pin |
| pin_pushpull | input | 17 | Drive mode for each pin: 1 push-pull, 0 open-drain |
| port_latch | input | 17 | Port latch bits that drive the GPIO pins |
| per_out | input | 12 | Peripheral signal values, one bit per signal index |
| per_in | output | 12 | Pin values returned to the peripherals, one bit per signal index |
| pin_in | input | 17 | Sensed value of each pin |
| pin_out | output | 17 | Registered output value of each pin |
| pin_oe | output | 17 | Registered output enable of each pin |
| pin_periph | output | 17 | Registered flag: 1 for a peripheral pin, 0 for GPIO |
| latch_rd | output | 17 | Registered readback of pin_in |
| overflow | output | 1 | Registered flag: not every enabled signal found a pin |

## Verification
The assertions assume that every input is known and changes only between clock edges. They also assume that pin_in is an independent input, not a loopback of pin_out. They are armed only one cycle after reset leaves the synchronizer, because the first load of the pin registers has not happened before that cycle. The stimulus changes all inputs on the falling edge. It covers skip patterns, enable sets, drive modes and sensed pin values in both chosen and random combinations. This includes configurations that leave no free pins at all and configurations with more signals than pins.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NPERIPH = 6;
  localparam int NSIG    = 12;

  // signal direction: 1 = peripheral input (pin not driven)
  localparam logic [NSIG-1:0] SIG_IS_IN = 12'b1100_0000_1010;

  // owning peripheral of each signal, in priority order
  function automatic int sig_owner(input int s);
    if (s < 2)       return 0;  // serial tx, rx
    else if (s < 6)  return 1;  // spi sck, miso, mosi, select
    else if (s < 8)  return 2;  // two-wire data, clock
    else if (s == 8) return 3;  // comparator out
    else if (s == 9) return 4;  // clock out
    else             return 5;  // capture inputs
  endfunction
endpackage

// File: rtl/xbar_prefix.sv
module xbar_prefix #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  logic [N-1:0]         mark,
  output logic [N-1:0][CW-1:0] rank,
  output logic [CW-1:0]        total
);
  logic [CW-1:0] acc;

  // rank[i] = number of marked entries below i
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc     = acc + CW'(mark[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int NXB  = 16,
  parameter int NSIG = 12,
  parameter int CW   = 5,
  parameter int PINW = 4,
  parameter int SIGW = 4
) (
  input  logic [NXB-1:0]            pin_free,
  input  logic [NXB-1:0][CW-1:0]    pin_rank,
  input  logic [CW-1:0]             free_total,
  input  logic [NSIG-1:0]           sig_en,
  input  logic [NSIG-1:0][CW-1:0]   sig_rank,
  input  logic [CW-1:0]             sig_total,
  output logic [NXB-1:0]            pin_take,
  output logic [NXB-1:0][SIGW-1:0]  pin_sig,
  output logic [NSIG-1:0]           sig_placed,
  output logic [NSIG-1:0][PINW-1:0] sig_pin
);
  // pin side: the k-th free pin carries the k-th enabled signal
  always_comb begin
    for (int p = 0; p < NXB; p++) begin
      pin_take[p] = pin_free[p] && (pin_rank[p] < sig_total);
      pin_sig[p]  = '0;
      for (int s = 0; s < NSIG; s++) begin
        if (sig_en[s] && (sig_rank[s] == pin_rank[p]))
          pin_sig[p] = SIGW'(s);
      end
    end
  end

  // signal side: the k-th enabled signal finds the k-th free pin
  always_comb begin
    for (int s = 0; s < NSIG; s++) begin
      sig_placed[s] = sig_en[s] && (sig_rank[s] < free_total);
      sig_pin[s]    = '0;
      for (int p = 0; p < NXB; p++) begin
        if (pin_free[p] && (pin_rank[p] == sig_rank[s]))
          sig_pin[s] = PINW'(p);
      end
    end
  end
endmodule

// File: rtl/xbar_pad.sv
module xbar_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic val_i,
  input  logic req_i,
  input  logic pp_i,
  input  logic pad_i,
  output logic out_o,
  output logic oe_o,
  output logic periph_o,
  output logic rd_o
);
  logic d_out, d_oe;

  // open-drain pulls low only; push-pull drives both levels
  always_comb begin
    d_out = pp_i ? val_i : 1'b0;
    d_oe  = req_i & (pp_i | ~val_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o    <= 1'b0;
      oe_o     <= 1'b0;
      periph_o <= 1'b0;
      rd_o     <= 1'b0;
    end else begin
      out_o    <= d_out;
      oe_o     <= d_oe;
      periph_o <= take_i;
      rd_o     <= pad_i;
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [5:0]                periph_en,
  input  logic [PORT_W*NUM_PORTS-1:0] pin_skip,
  input  logic [PORT_W*NUM_PORTS:0] pin_pushpull,
  input  logic [PORT_W*NUM_PORTS:0] port_latch,
  input  logic [11:0]               per_out,
  output logic [11:0]               per_in,
  input  logic [PORT_W*NUM_PORTS:0] pin_in,
  output logic [PORT_W*NUM_PORTS:0] pin_out,
  output logic [PORT_W*NUM_PORTS:0] pin_oe,
  output logic [PORT_W*NUM_PORTS:0] pin_periph,
  output logic [PORT_W*NUM_PORTS:0] latch_rd,
  output logic                      overflow
);
  import xbar_pkg::*;

  localparam int NXB  = PORT_W * NUM_PORTS;
  localparam int NPIN = NXB + 1;
  localparam int CW   = $clog2(((NXB > NSIG) ? NXB : NSIG) + 1);
  localparam int PINW = $clog2(NXB);
  localparam int SIGW = $clog2(NSIG);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync, live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // per-signal enables from owning peripheral
  logic [NSIG-1:0] sig_en;
  for (genvar s = 0; s < NSIG; s++) begin : g_sig_en
    assign sig_en[s] = periph_en[sig_owner(s)];
  end

  logic [NXB-1:0]            pin_free;
  logic [NXB-1:0][CW-1:0]    pin_rank;
  logic [CW-1:0]             free_total;
  logic [NSIG-1:0][CW-1:0]   sig_rank;
  logic [CW-1:0]             sig_total;
  logic [NXB-1:0]            pin_take;
  logic [NXB-1:0][SIGW-1:0]  pin_sig;
  logic [NSIG-1:0]           sig_placed;
  logic [NSIG-1:0][PINW-1:0] sig_pin;

  assign pin_free = ~pin_skip;

  xbar_prefix #(.N(NXB), .CW(CW)) u_pin_rank (
    .mark (pin_free),
    .rank (pin_rank),
    .total(free_total)
  );

  xbar_prefix #(.N(NSIG), .CW(CW)) u_sig_rank (
    .mark (sig_en),
    .rank (sig_rank),
    .total(sig_total)
  );

  xbar_route #(.NXB(NXB), .NSIG(NSIG), .CW(CW), .PINW(PINW), .SIGW(SIGW)) u_route (
    .pin_free  (pin_free),
    .pin_rank  (pin_rank),
    .free_total(free_total),
    .sig_en    (sig_en),
    .sig_rank  (sig_rank),
    .sig_total (sig_total),
    .pin_take  (pin_take),
    .pin_sig   (pin_sig),
    .sig_placed(sig_placed),
    .sig_pin   (sig_pin)
  );

  // drive source per pin: peripheral signal or port latch
  logic [NPIN-1:0] take_all, drv_val, drv_req;
  always_comb begin
    for (int p = 0; p < NXB; p++) begin
      take_all[p] = pin_take[p];
      if (pin_take[p]) begin
        drv_val[p] = SIG_IS_IN[pin_sig[p]] ? 1'b0 : per_out[pin_sig[p]];
        drv_req[p] = ~SIG_IS_IN[pin_sig[p]];
      end else begin
        drv_val[p] = port_latch[p];
        drv_req[p] = 1'b1;
      end
    end
    take_all[NPIN-1] = 1'b0;
    drv_val[NPIN-1]  = port_latch[NPIN-1];
    drv_req[NPIN-1]  = 1'b1;
  end

  // return path: unplaced signals read idle high
  always_comb begin
    for (int s = 0; s < NSIG; s++)
      per_in[s] = sig_placed[s] ? pin_in[sig_pin[s]] : 1'b1;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    xbar_pad u_pad (
      .clk     (clk),
      .rst_n   (rst_sync),
      .take_i  (take_all[p]),
      .val_i   (drv_val[p]),
      .req_i   (drv_req[p]),
      .pp_i    (pin_pushpull[p]),
      .pad_i   (pin_in[p]),
      .out_o   (pin_out[p]),
      .oe_o    (pin_oe[p]),
      .periph_o(pin_periph[p]),
      .rd_o    (latch_rd[p])
    );
  end

  logic ovf_d;
  always_comb ovf_d = (sig_total > free_total);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      overflow <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      overflow <= ovf_d;
      live_q   <= 1'b1;
    end
  end

  AST_SKIP_NOT_PERIPH: assert property (@(posedge clk) disable iff (!live_q)
    ((pin_periph[NXB-1:0] & $past(pin_skip)) == '0)); // R3

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!live_q)
    ((pin_oe & pin_out & ~$past(pin_pushpull)) == '0)); // R6

  AST_GPIO_FROM_LATCH: assert property (@(posedge clk) disable iff (!live_q)
    ((~pin_periph & $past(pin_pushpull) & (pin_out ^ $past(port_latch))) == '0)); // R4

  AST_FULL_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!live_q)
    overflow |-> ($countones(pin_periph) == $countones(~$past(pin_skip)))); // R7

  AST_READBACK: assert property (@(posedge clk) disable iff (!live_q)
    (latch_rd == $past(pin_in))); // R8
endmodule

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  periph_en;
  logic [15:0] pin_skip;
  logic [16:0] pin_pushpull, port_latch, pin_in;
  logic [11:0] per_out;
  logic [11:0] per_in;
  logic [16:0] pin_out, pin_oe, pin_periph, latch_rd;
  logic        overflow;

  always #5 clk = ~clk;

  pin_xbar u0 (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .pin_skip(pin_skip),
    .pin_pushpull(pin_pushpull), .port_latch(port_latch), .per_out(per_out),
    .per_in(per_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_periph(pin_periph), .latch_rd(latch_rd), .overflow(overflow)
  );

  typedef struct {
    logic [16:0] out, oe, periph, rd;
    logic [11:0] pin_r;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int own_tbl [12] = '{0, 0, 1, 1, 1, 1, 2, 2, 3, 4, 5, 5};
  logic [11:0] is_in = 12'b1100_0000_1010;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply stimulus at the falling edge, predict, queue
  task automatic drive(input logic [5:0] en, input logic [15:0] skip, input logic [16:0] pp,
                       input logic [16:0] lat, input logic [11:0] po, input logic [16:0] pi,
                       input string tag);
    exp_t e;
    int pin_s [16];
    int s_pin [12];
    int ptr;
    logic v, r;
    @(negedge clk);
    periph_en = en; pin_skip = skip; pin_pushpull = pp;
    port_latch = lat; per_out = po; pin_in = pi;
    foreach (pin_s[i]) pin_s[i] = -1;
    foreach (s_pin[i]) s_pin[i] = -1;
    e.ovf = 1'b0;
    ptr = 0;
    for (int s = 0; s < 12; s++) begin
      if (en[own_tbl[s]]) begin
        while (ptr < 16 && skip[ptr]) ptr++;
        if (ptr < 16) begin pin_s[ptr] = s; s_pin[s] = ptr; ptr++; end
        else e.ovf = 1'b1;
      end
    end
    for (int p = 0; p < 17; p++) begin
      if (p < 16 && pin_s[p] >= 0) begin
        e.periph[p] = 1'b1;
        v = is_in[pin_s[p]] ? 1'b0 : po[pin_s[p]];
        r = ~is_in[pin_s[p]];
      end else begin
        e.periph[p] = 1'b0;
        v = lat[p];
        r = 1'b1;
      end
      e.out[p] = pp[p] ? v : 1'b0;
      e.oe[p]  = r & (pp[p] | ~v);
    end
    for (int s = 0; s < 12; s++) e.pin_r[s] = (s_pin[s] >= 0) ? pi[s_pin[s]] : 1'b1;
    e.rd  = pi;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: registered outputs settle one edge after drive (R9)
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, "/R6"}, "pin_out",    32'(pin_out),    32'(e.out));
        chk({e.tag, "/R6"}, "pin_oe",     32'(pin_oe),     32'(e.oe));
        chk({e.tag, "/R3"}, "pin_periph", 32'(pin_periph), 32'(e.periph));
        chk({e.tag, "/R5"}, "per_in",     32'(per_in),     32'(e.pin_r));
        chk({e.tag, "/R7"}, "overflow",   32'(overflow),   32'(e.ovf));
        chk({e.tag, "/R8"}, "latch_rd",   32'(latch_rd),   32'(e.rd));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    periph_en = '0; pin_skip = '0; pin_pushpull = '1;
    port_latch = 17'h1A5C3; per_out = '0; pin_in = 17'h0F0F0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1", "pin_out reset",    32'(pin_out),    0);
    chk("R1", "pin_oe reset",     32'(pin_oe),     0);
    chk("R1", "pin_periph reset", 32'(pin_periph), 0);
    chk("R1", "latch_rd reset",   32'(latch_rd),   0);
    chk("R1", "overflow reset",   32'(overflow),   0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R4: nothing enabled, all GPIO from the latch
    drive(6'h00, 16'h0000, '1, 17'h1A5C3, 12'hFFF, 17'h05555, "R4");
    // R2: serial only at pins 0 and 1
    drive(6'h01, 16'h0000, '1, 17'h00000, 12'h001, 17'h00002, "R2");
    // R2/R3: serial + spi around skipped pins 0 and 3
    drive(6'h03, 16'h0009, '1, 17'h1FFFF, 12'h015, 17'h000A4, "R2");
    // R2: clock out alone takes pin 0
    drive(6'h10, 16'h0000, '1, 17'h00000, 12'h200, 17'h00000, "R2");
    // R7: all enabled, only four free pins
    drive(6'h3F, 16'hFFF0, '1, 17'h12345, 12'hAAA, 17'h0000F, "R7");
    // R7/R3: every pin skipped
    drive(6'h21, 16'hFFFF, '1, 17'h0F0F0, 12'hFFF, 17'h1FFFF, "R7");
    // R6: open-drain everywhere
    drive(6'h05, 16'h0000, '0, 17'h1C3A5, 12'h0C5, 17'h0FFFF, "R6");
    // R4: all enabled, fits; pin 16 stays GPIO
    drive(6'h3F, 16'h0000, '1, 17'h10000, 12'hFFF, 17'h10C02, "R4");
    // R5: two-wire and capture inputs reading back sensed pins
    drive(6'h24, 16'h00F0, 17'h0FF00, 17'h000FF, 12'h0C0, 17'h0000C, "R5");
    // R9: back-to-back changes, each seen one edge later
    drive(6'h02, 16'h0000, '1, 17'h0, 12'h014, 17'h00002, "R9");
    drive(6'h00, 16'h0000, '1, 17'h1FFFF, 12'h000, 17'h00000, "R9");
    for (int i = 0; i < 60; i++) begin
      drive(6'($urandom), 16'($urandom), 17'($urandom), 17'($urandom),
            12'($urandom), 17'($urandom), "R2");
    end
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule